// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block models one function unit of an SRAM-configured logic array. It holds four 16-entry, 1-bit lookup tables and four storage elements. A three-bit mode input decides how the tables are used. They can be four independent 4-input functions, two 5-input functions, or one 6-input function. They can also form a 4-bit ripple adder with carry in and carry out, a 16x4 synchronous RAM, a 16x4 ROM, or a 16x2 memory with separate write and read addresses.

Table contents are loaded in parallel from a configuration word with a one-cycle strobe. The combinational results drive four outputs and the D inputs of four registers. The registers have a clock enable, a synchronous local reset and a global reset, and each register's reset value comes from its own configuration bit. By default the global reset is asynchronous; a parameter selects a synchronous version.

Top module: `logic_cell`

## Requirements
- R1: When `cfg_wr` is high at a rising clock edge, every table is loaded from `cfg_tables`. Table k entry e is bit k*16+e. This load takes priority over any memory write in the same cycle. In mode 0 (four functions), `f[3]`/`f[2]` are tables 3/2 read at `addr_a`, and `f[1]`/`f[0]` are tables 1/0 read at `addr_b`.
- R2: In mode 1 (five-input), `f[0]` is table 1 at `addr_b` when `sel_b` is 1, otherwise table 0 at `addr_b`. `f[2]` is table 3 at `addr_a` when `sel_a` is 1, otherwise table 2 at `addr_a`. `f[1]` and `f[3]` are table 1 at `addr_b` and table 3 at `addr_a`.
- R3: In mode 2 (six-input), all four bits of `f` equal table number {sel_a,sel_b} read at `addr_a`.
- R4: In mode 3 (ripple), {`carry_out`,`f`} equals `addr_a[3:0]` + `addr_b[3:0]` + `carry_in` in the same cycle. In every other mode, `carry_out` is 0.
- R5: In mode 4 (RAM), `f[k]` is table k at `addr_a`. When `wr_en` is high at a rising edge, `wdata[k]` is written to table k at `addr_a`.
- R6: In mode 5 (ROM), reads are the same as in mode 4, and `wr_en` has no effect on the tables.
- R7: In mode 6 (dual-port), a write stores `wdata[1:0]` in tables 1:0 at `addr_a`. `f[1:0]` reads tables 1:0 at `addr_a`, and `f[3:2]` reads tables 1:0 at `addr_b`. Tables 2 and 3 are not written.
- R8: In mode 6, if `addr_b` equals `addr_a` in a write cycle, `f[3:2]` shows the old word until the clock edge.
- R9: At a rising edge with `gsr` and `lsr` low, `q` loads `f` when `clk_en` is 1, and holds its value when `clk_en` is 0.
- R10: `lsr` high at a rising edge loads `q` with `cfg_rst_val`, whatever `clk_en` is.
- R11: `gsr` high forces `q` to `cfg_rst_val` and overrides `lsr` and `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| gsr | input | 1 | Global set/reset, active high |
| lsr | input | 1 | Local synchronous set/reset |
| clk_en | input | 1 | Register clock enable |
| cfg_mode | input | 3 | Operating mode, 0 to 6 |
| cfg_wr | input | 1 | Table load strobe |
| cfg_tables | input | 64 | Table load image |
| cfg_rst_val | input | 4 | Per-register reset value |
| addr_a | input | 4 | Address for tables 3:2, RAM address, adder operand |
| addr_b | input | 4 | Address for tables 1:0, read port address, adder operand |
| sel_a | input | 1 | Fifth/sixth function input |
| sel_b | input | 1 | Fifth/sixth function input |
| carry_in | input | 1 | Ripple carry input |
| wdata | input | 4 | Memory write data |
| wr_en | input | 1 | Memory write enable |
| f | output | 4 | Combinational outputs |
| q | output | 4 | Registered outputs |
| carry_out | output | 1 | Ripple carry output |

## Verification
Four properties are checked on every cycle: the adder sum and the zero carry outside ripple mode, the matching bits of the six-input mode, register capture, hold and local reset, and RAM read-after-write. Other behaviours can only be shown by the bench's scenarios, because they depend on table contents over time. These are the lookup results in each function mode, the config load winning over a memory write, the ROM ignoring writes, the dual-port old-data read, and global reset overriding the other controls. The bench follows these with a behavioural model of the table contents.

// File: rtl/cell_pkg.sv
package cell_pkg;
   localparam int NUM_TBL = 4;

   typedef enum logic [2:0] {
      MD_LUT4  = 3'd0,
      MD_LUT5  = 3'd1,
      MD_LUT6  = 3'd2,
      MD_ADD   = 3'd3,
      MD_RAM   = 3'd4,
      MD_ROM   = 3'd5,
      MD_DPRAM = 3'd6
   } cell_mode_e;
endpackage

// File: rtl/cell_tables.sv
module cell_tables
   import cell_pkg::*;
#(
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic                     clk,
   input  logic                     cfg_wr,
   input  logic [NUM_TBL*DEPTH-1:0] cfg_tables,
   input  cell_mode_e               mode,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [NUM_TBL-1:0]       wdata,
   output logic [NUM_TBL*DEPTH-1:0] tbl_q
);
   for (genvar k = 0; k < NUM_TBL; k++) begin : g_tbl
      // tables 0 and 1 also form the dual-port memory
      localparam bit IN_DP = (k < 2);
      logic [DEPTH-1:0] mem;
      logic             wr_ok;

      assign wr_ok = wr_en && ((mode == MD_RAM) || (IN_DP && mode == MD_DPRAM));

      always_ff @(posedge clk) begin
         if (cfg_wr)
            mem <= cfg_tables[k*DEPTH +: DEPTH];
         else if (wr_ok)
            mem[wr_addr] <= wdata[k];
      end

      assign tbl_q[k*DEPTH +: DEPTH] = mem;
   end
endmodule

// File: rtl/cell_eval.sv
module cell_eval
   import cell_pkg::*;
#(
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic [NUM_TBL*DEPTH-1:0] tbl_q,
   input  cell_mode_e               mode,
   input  logic [ADDR_W-1:0]        addr_a,
   input  logic [ADDR_W-1:0]        addr_b,
   input  logic                     sel_a,
   input  logic                     sel_b,
   input  logic                     carry_in,
   output logic [NUM_TBL-1:0]       f,
   output logic                     carry_out
);
   logic [NUM_TBL-1:0] ra, rb, sum;
   logic [NUM_TBL:0]   cy;

   for (genvar k = 0; k < NUM_TBL; k++) begin : g_rd
      logic [DEPTH-1:0] t;
      assign t     = tbl_q[k*DEPTH +: DEPTH];
      assign ra[k] = t[addr_a];
      assign rb[k] = t[addr_b];
   end

   assign cy[0] = carry_in;
   for (genvar i = 0; i < NUM_TBL; i++) begin : g_slice
      logic p;
      assign p         = addr_a[i] ^ addr_b[i];
      assign sum[i]    = p ^ cy[i];
      assign cy[i+1]   = (addr_a[i] & addr_b[i]) | (p & cy[i]);
   end

   always_comb begin
      f         = '0;
      carry_out = 1'b0;
      unique case (mode)
         MD_LUT4:  f = {ra[3], ra[2], rb[1], rb[0]};
         MD_LUT5:  f = {ra[3], sel_a ? ra[3] : ra[2], rb[1], sel_b ? rb[1] : rb[0]};
         MD_LUT6:  f = {NUM_TBL{ra[{sel_a, sel_b}]}};
         MD_ADD: begin
            f         = sum;
            carry_out = cy[NUM_TBL];
         end
         MD_RAM, MD_ROM: f = ra;
         MD_DPRAM: f = {rb[1], rb[0], ra[1], ra[0]};
         default:  f = '0;
      endcase
   end
endmodule

// File: rtl/cell_regs.sv
module cell_regs
   import cell_pkg::*;
#(
   parameter bit GSR_ASYNC = 1'b1
) (
   input  logic               clk,
   input  logic               gsr,
   input  logic               lsr,
   input  logic               clk_en,
   input  logic [NUM_TBL-1:0] rst_val,
   input  logic [NUM_TBL-1:0] d,
   output logic [NUM_TBL-1:0] q
);
   for (genvar i = 0; i < NUM_TBL; i++) begin : g_ff
      if (GSR_ASYNC) begin : g_async
         always_ff @(posedge clk or posedge gsr) begin
            if (gsr)         q[i] <= rst_val[i];
            else if (lsr)    q[i] <= rst_val[i];
            else if (clk_en) q[i] <= d[i];
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (gsr)         q[i] <= rst_val[i];
            else if (lsr)    q[i] <= rst_val[i];
            else if (clk_en) q[i] <= d[i];
         end
      end
   end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
   import cell_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter bit GSR_ASYNC = 1'b1,
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic                     clk,
   input  logic                     gsr,
   input  logic                     lsr,
   input  logic                     clk_en,
   input  logic [2:0]               cfg_mode,
   input  logic                     cfg_wr,
   input  logic [NUM_TBL*DEPTH-1:0] cfg_tables,
   input  logic [NUM_TBL-1:0]       cfg_rst_val,
   input  logic [ADDR_W-1:0]        addr_a,
   input  logic [ADDR_W-1:0]        addr_b,
   input  logic                     sel_a,
   input  logic                     sel_b,
   input  logic                     carry_in,
   input  logic [NUM_TBL-1:0]       wdata,
   input  logic                     wr_en,
   output logic [NUM_TBL-1:0]       f,
   output logic [NUM_TBL-1:0]       q,
   output logic                     carry_out
);
   if (ADDR_W < NUM_TBL || ADDR_W > 8) begin : g_bad_addr_w
      $error("logic_cell: ADDR_W must lie in [NUM_TBL, 8]");
   end
   if (NUM_TBL != 4) begin : g_bad_num_tbl
      $error("logic_cell: output mapping assumes four tables");
   end

   cell_mode_e               mode;
   logic [NUM_TBL*DEPTH-1:0] tbl_q;

   assign mode = cell_mode_e'(cfg_mode);

   cell_tables #(.ADDR_W(ADDR_W)) u_tables (
      .clk       (clk),
      .cfg_wr    (cfg_wr),
      .cfg_tables(cfg_tables),
      .mode      (mode),
      .wr_en     (wr_en),
      .wr_addr   (addr_a),
      .wdata     (wdata),
      .tbl_q     (tbl_q)
   );

   cell_eval #(.ADDR_W(ADDR_W)) u_eval (
      .tbl_q    (tbl_q),
      .mode     (mode),
      .addr_a   (addr_a),
      .addr_b   (addr_b),
      .sel_a    (sel_a),
      .sel_b    (sel_b),
      .carry_in (carry_in),
      .f        (f),
      .carry_out(carry_out)
   );

   cell_regs #(.GSR_ASYNC(GSR_ASYNC)) u_regs (
      .clk    (clk),
      .gsr    (gsr),
      .lsr    (lsr),
      .clk_en (clk_en),
      .rst_val(cfg_rst_val),
      .d      (f),
      .q      (q)
   );
endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk
   import cell_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic               clk,
   input logic               gsr,
   input logic               lsr,
   input logic               clk_en,
   input logic [2:0]         cfg_mode,
   input logic               cfg_wr,
   input logic [NUM_TBL-1:0] cfg_rst_val,
   input logic [ADDR_W-1:0]  addr_a,
   input logic [ADDR_W-1:0]  addr_b,
   input logic               carry_in,
   input logic [NUM_TBL-1:0] wdata,
   input logic               wr_en,
   input logic [NUM_TBL-1:0] f,
   input logic [NUM_TBL-1:0] q,
   input logic               carry_out
);
   // R4
   ripple_sum_chk: assert property (@(posedge clk) disable iff (gsr)
      (cfg_mode == 3'd3) |-> ({carry_out, f} ==
         ({1'b0, addr_a[NUM_TBL-1:0]} + {1'b0, addr_b[NUM_TBL-1:0]} + {{NUM_TBL{1'b0}}, carry_in})));

   // R4
   carry_idle_chk: assert property (@(posedge clk) disable iff (gsr)
      (cfg_mode != 3'd3) |-> (carry_out == 1'b0));

   // R3
   lut6_uniform_chk: assert property (@(posedge clk) disable iff (gsr)
      (cfg_mode == 3'd2) |-> (f == '0 || f == '1));

   // R9
   reg_capture_chk: assert property (@(posedge clk) disable iff (gsr)
      (!lsr && clk_en) |=> (q == $past(f)));

   // R9
   reg_hold_chk: assert property (@(posedge clk) disable iff (gsr)
      (!lsr && !clk_en) |=> $stable(q));

   // R10
   lsr_load_chk: assert property (@(posedge clk) disable iff (gsr)
      lsr |=> (q == $past(cfg_rst_val)));

   // R5
   ram_readback_chk: assert property (@(posedge clk) disable iff (gsr)
      (cfg_mode == 3'd4 && wr_en && !cfg_wr) |=>
         (cfg_mode != 3'd4 || addr_a != $past(addr_a) || f == $past(wdata)));
endmodule

bind logic_cell logic_cell_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_logic_cell.sv
`timescale 1ns/1ps
module sim_logic_cell;
   logic        clk = 1'b0;
   logic        gsr, lsr, clk_en, cfg_wr, sel_a, sel_b, carry_in, wr_en;
   logic [2:0]  cfg_mode;
   logic [63:0] cfg_tables;
   logic [3:0]  cfg_rst_val, addr_a, addr_b, wdata;
   logic [3:0]  f, q;
   logic        carry_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   bit [15:0] tm [4];
   bit [3:0]  mq;
   bit [3:0]  ef;
   bit        eco;

   always #4 clk = ~clk;

   logic_cell u0 (
      .clk(clk), .gsr(gsr), .lsr(lsr), .clk_en(clk_en), .cfg_mode(cfg_mode),
      .cfg_wr(cfg_wr), .cfg_tables(cfg_tables), .cfg_rst_val(cfg_rst_val),
      .addr_a(addr_a), .addr_b(addr_b), .sel_a(sel_a), .sel_b(sel_b),
      .carry_in(carry_in), .wdata(wdata), .wr_en(wr_en),
      .f(f), .q(q), .carry_out(carry_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic void model_f();
      int a = int'(addr_a);
      int b = int'(addr_b);
      int s;
      eco = 1'b0;
      ef  = '0;
      case (cfg_mode)
         3'd0: ef = {tm[3][a], tm[2][a], tm[1][b], tm[0][b]};
         3'd1: ef = {tm[3][a], (sel_a ? tm[3][a] : tm[2][a]),
                     tm[1][b], (sel_b ? tm[1][b] : tm[0][b])};
         3'd2: ef = {4{tm[int'({sel_a, sel_b})][a]}};
         3'd3: begin
            s   = a + b + int'(carry_in);
            ef  = s[3:0];
            eco = s[4];
         end
         3'd4, 3'd5: ef = {tm[3][a], tm[2][a], tm[1][a], tm[0][a]};
         3'd6: ef = {tm[1][b], tm[0][b], tm[1][a], tm[0][a]};
         default: ef = '0;
      endcase
   endfunction

   task automatic cyc(input bit [2:0] md, input bit [3:0] a, input bit [3:0] b,
                      input bit sa, input bit sb, input bit ci, input bit [3:0] wd,
                      input bit we, input bit en, input bit l, input bit g, input bit cw);
      string ftag, qtag;
      @(negedge clk);
      cfg_mode = md; addr_a = a; addr_b = b; sel_a = sa; sel_b = sb;
      carry_in = ci; wdata = wd; wr_en = we; clk_en = en; lsr = l; gsr = g; cfg_wr = cw;
      #1;
      model_f();
      case (md)
         3'd0: ftag = "R1";
         3'd1: ftag = "R2";
         3'd2: ftag = "R3";
         3'd3: ftag = "R4";
         3'd4: ftag = "R5";
         3'd5: ftag = "R6";
         default: ftag = (we && a == b) ? "R8" : "R7";
      endcase
      chk(ftag, int'(f), int'(ef));
      chk("R4", int'(carry_out), int'(eco));
      @(posedge clk);
      #1;
      if (g)       begin mq = cfg_rst_val; qtag = "R11"; end
      else if (l)  begin mq = cfg_rst_val; qtag = "R10"; end
      else begin
         if (en) mq = ef;
         qtag = "R9";
      end
      if (cw) begin
         for (int k = 0; k < 4; k++) tm[k] = cfg_tables[k*16 +: 16];
      end else if (we && md == 3'd4) begin
         for (int k = 0; k < 4; k++) tm[k][a] = wd[k];
      end else if (we && md == 3'd6) begin
         tm[0][a] = wd[0];
         tm[1][a] = wd[1];
      end
      chk(qtag, int'(q), int'(mq));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      gsr = 1'b1; lsr = 1'b0; clk_en = 1'b0; cfg_wr = 1'b0; cfg_mode = 3'd0;
      addr_a = '0; addr_b = '0; sel_a = 1'b0; sel_b = 1'b0; carry_in = 1'b0;
      wdata = '0; wr_en = 1'b0;
      cfg_tables  = 64'h6996_F00F_3C5A_8E17;
      cfg_rst_val = 4'b1010;
      // reset state, with table load: R11 and R1
      cyc(3'd0, 4'd3, 4'd9, 0, 0, 0, 4'h0, 0, 1, 0, 1, 1);
      chk("R11", int'(q), 4'b1010);
      // gsr beats lsr and enable
      cyc(3'd0, 4'd1, 4'd2, 0, 0, 0, 4'h0, 0, 1, 1, 1, 0);
      cyc(3'd0, 4'd1, 4'd2, 0, 0, 0, 4'h0, 0, 1, 0, 0, 0);

      for (int md = 0; md < 7; md++) begin
         for (int n = 0; n < 40; n++) begin
            bit [3:0] a  = 4'($urandom_range(0, 15));
            bit [3:0] b  = 4'($urandom_range(0, 15));
            bit       we = bit'($urandom_range(0, 1));
            bit       en = ($urandom_range(0, 3) != 0);
            bit       cw = (n == 0 && md != 5);
            if (cw) cfg_tables = {$urandom, $urandom};
            if (n == 20) cfg_rst_val = ~cfg_rst_val;
            cyc(3'(md), a, (n % 9 == 4) ? a : b, bit'($urandom_range(0, 1)),
                bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                4'($urandom_range(0, 15)), cw ? 1'b1 : we, en,
                (n % 13 == 5), (n % 17 == 16), cw);
         end
      end

      // ripple boundaries: R4
      cyc(3'd3, 4'hF, 4'h0, 0, 0, 1, 4'h0, 0, 1, 0, 0, 0);
      chk("R4", int'(carry_out), 1);
      cyc(3'd3, 4'hF, 4'hF, 0, 0, 1, 4'h0, 0, 1, 0, 0, 0);
      cyc(3'd3, 4'h0, 4'h0, 0, 0, 0, 4'h0, 0, 1, 0, 0, 0);

      // dual-port same-address write then read: R8 and R7
      cyc(3'd6, 4'd5, 4'd5, 0, 0, 0, 4'h3, 1, 0, 0, 0, 0);
      cyc(3'd6, 4'd5, 4'd5, 0, 0, 0, 4'h0, 0, 0, 0, 0, 0);
      chk("R7", int'(f[3:2]), 3);
      cyc(3'd6, 4'd5, 4'd5, 0, 0, 0, 4'h0, 1, 0, 0, 0, 0);
      cyc(3'd6, 4'd5, 4'd5, 0, 0, 0, 4'h0, 0, 0, 0, 0, 0);
      chk("R8", int'(f[3:2]), 0);

      // ROM ignores writes: R6
      cyc(3'd5, 4'd7, 4'd0, 0, 0, 0, ~ef, 1, 1, 0, 0, 0);
      cyc(3'd5, 4'd7, 4'd0, 0, 0, 0, 4'h0, 0, 1, 0, 0, 0);

      // config load wins over RAM write: R1
      cfg_tables = 64'h0;
      cyc(3'd4, 4'd2, 4'd0, 0, 0, 0, 4'hF, 1, 1, 0, 0, 1);
      cyc(3'd4, 4'd2, 4'd0, 0, 0, 0, 4'h0, 0, 1, 0, 0, 0);
      chk("R1", int'(f), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule